// File: doc/BRIEF.md
# Predicated Execution and Condition Flag Unit

This block sits in the execute stage of a 32-bit processor. It decides whether each issued instruction commits, and it holds the four condition flags: negative, zero, carry and overflow. Each instruction carries a 4-bit predicate code in its top bits. The block tests that code against the flags held in the block. An instruction whose predicate fails becomes a no-op: it writes no register and changes no flag.

When an instruction commits, the flags are reloaded from the ALU outputs in two cases. The first is an instruction that has its set-flags bit raised. The second is a compare-class operation, which always loads the flags and never writes a destination register. The flag register is the only state in the block. A flag update made at a clock edge is seen by the predicate test of the instruction issued in the very next cycle.

The predicate test and both enables are combinational from the current inputs and the held flags. Each predicate code is handled as a base test plus an inversion bit, so the two codes of a pair share one evaluator.

Top module: `cx_cond_unit`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), and after it is released until the first flag update, the four flags read 0.
- R2: exec_en is high in the same cycle as issue_valid exactly when the predicate code holds against the current flags, where Z, C, N and V are the held flags. The codes are: 0x0 Z, 0x1 !Z, 0x2 C, 0x3 !C, 0x4 N, 0x5 !N, 0x6 V, 0x7 !V, 0x8 C&!Z, 0x9 !(C&!Z), 0xA N==V, 0xB N!=V, 0xC !Z&(N==V), 0xD !(!Z&(N==V)).
- R3: Predicate code 0xE executes for every flag value.
- R4: Predicate code 0xF never executes, for every flag value.
- R5: An issued instruction whose predicate fails drives reg_wr_en low and leaves the flags unchanged, even when set_flags or cmp_op is high.
- R6: A committed instruction with set_flags high loads the flags at the next clock edge. N is alu_result bit 31, Z is high when alu_result is zero, C is alu_carry and V is alu_ovf. The predicate test of the next cycle's instruction sees the new values.
- R7: A committed non-compare instruction with set_flags low drives reg_wr_en high and leaves the flags unchanged.
- R8: A committed compare (cmp_op high) loads the flags as in R6 whatever the value of set_flags, and drives reg_wr_en low.
- R9: While issue_valid is low, exec_en and reg_wr_en are low and the flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | An instruction is presented this cycle |
| pred_code | input | 4 | Predicate field of the instruction |
| set_flags | input | 1 | Instruction requests a flag update |
| cmp_op | input | 1 | Compare-class operation (flags only, no register write) |
| alu_result | input | 32 | ALU result of the instruction |
| alu_carry | input | 1 | ALU carry-out |
| alu_ovf | input | 1 | ALU signed overflow |
| exec_en | output | 1 | Instruction commits |
| reg_wr_en | output | 1 | Destination register write enable |
| flag_n | output | 1 | Held negative flag |
| flag_z | output | 1 | Held zero flag |
| flag_c | output | 1 | Held carry flag |
| flag_v | output | 1 | Held overflow flag |

## Verification
exec_en and reg_wr_en are due in the same cycle as the instruction. The bench drives each instruction just after a falling edge and samples both enables one nanosecond later, well before the next rising edge. New flag values are due one rising edge after the committing instruction. The bench checks them at the following falling edge, and also through the predicate result of the instruction issued in that cycle, which tests the zero-latency rule. To preset the flags, the bench issues an always-executing compare one cycle before each predicate test.

// File: rtl/cx_pkg.sv
package cx_pkg;

    localparam int PRED_W = 4;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } cx_flags_t;

    typedef enum logic [2:0] {
        BASE_ZERO   = 3'd0,
        BASE_CARRY  = 3'd1,
        BASE_NEG    = 3'd2,
        BASE_OVF    = 3'd3,
        BASE_UHIGH  = 3'd4,
        BASE_SGE    = 3'd5,
        BASE_SGT    = 3'd6,
        BASE_TRUE   = 3'd7
    } cx_base_e;

endpackage

// File: rtl/cx_pred_eval.sv
module cx_pred_eval
    import cx_pkg::*;
(
    input  logic [PRED_W-1:0] pred_i,
    input  cx_flags_t         flags_i,
    output logic              pass_o
);
    localparam int BASE_W = PRED_W - 1;

    cx_base_e   base;
    logic       invert;
    logic       base_true;
    logic       sign_eq;

    assign base   = cx_base_e'(pred_i[PRED_W-1:1]);
    assign invert = pred_i[0];
    assign sign_eq = (flags_i.n == flags_i.v);

    always_comb begin
        unique case (base)
            BASE_ZERO:  base_true = flags_i.z;
            BASE_CARRY: base_true = flags_i.c;
            BASE_NEG:   base_true = flags_i.n;
            BASE_OVF:   base_true = flags_i.v;
            BASE_UHIGH: base_true = flags_i.c & ~flags_i.z;
            BASE_SGE:   base_true = sign_eq;
            BASE_SGT:   base_true = ~flags_i.z & sign_eq;
            default:    base_true = 1'b1;
        endcase
    end

    // The odd code of each pair is the complement; for the top pair that
    // turns "always" into "never".
    assign pass_o = base_true ^ invert;

    // R3 / R4: top pair is flag-independent
    always_comb begin
        if (pred_i == {BASE_W'(BASE_TRUE), 1'b0})
            assert_always_true_R3: assert (pass_o === 1'b1 || $isunknown(flags_i));
        if (pred_i == {BASE_W'(BASE_TRUE), 1'b1})
            assert_never_true_R4: assert (pass_o === 1'b0 || $isunknown(flags_i));
    end

endmodule

// File: rtl/cx_flag_calc.sv
module cx_flag_calc
    import cx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] result_i,
    input  logic              carry_i,
    input  logic              ovf_i,
    output cx_flags_t         flags_o
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        flags_o.n = result_i[MSB];
        flags_o.z = ~|result_i;
        flags_o.c = carry_i;
        flags_o.v = ovf_i;
    end

endmodule

// File: rtl/cx_flag_reg.sv
module cx_flag_reg
    import cx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_i,
    input  cx_flags_t new_i,
    output cx_flags_t flags_o
);
    typedef struct packed {
        cx_flags_t flags;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i)
            st_d.flags = new_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(flags_o));

    assert_flags_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> flags_o == $past(new_i));

endmodule

// File: rtl/cx_cond_unit.sv
module cx_cond_unit
    import cx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [PRED_W-1:0] pred_code,
    input  logic              set_flags,
    input  logic              cmp_op,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              alu_carry,
    input  logic              alu_ovf,
    output logic              exec_en,
    output logic              reg_wr_en,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v
);
    cx_flags_t flags_q;
    cx_flags_t flags_new;
    logic      pred_pass;
    logic      flag_load;

    cx_pred_eval u_pred (
        .pred_i  (pred_code),
        .flags_i (flags_q),
        .pass_o  (pred_pass)
    );

    cx_flag_calc #(.DATA_W(DATA_W)) u_calc (
        .result_i (alu_result),
        .carry_i  (alu_carry),
        .ovf_i    (alu_ovf),
        .flags_o  (flags_new)
    );

    always_comb begin
        exec_en   = issue_valid & pred_pass;
        reg_wr_en = exec_en & ~cmp_op;
        flag_load = exec_en & (set_flags | cmp_op);
    end

    cx_flag_reg u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (flag_load),
        .new_i   (flags_new),
        .flags_o (flags_q)
    );

    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_c = flags_q.c;
    assign flag_v = flags_q.v;

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> !exec_en && !reg_wr_en);

    assert_idle_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> $stable({flag_n, flag_z, flag_c, flag_v}));

    assert_cmp_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_op |-> !reg_wr_en);

    assert_write_needs_exec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> exec_en);

    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en && (set_flags || cmp_op) |=> flag_z == ($past(alu_result) == '0));

    assert_no_s_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && !set_flags && !cmp_op |=> $stable({flag_n, flag_z, flag_c, flag_v}));

endmodule

// File: tb/tb_cx_cond_unit.sv
module tb_cx_cond_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue_valid;
    logic [3:0]  pred_code;
    logic        set_flags;
    logic        cmp_op;
    logic [31:0] alu_result;
    logic        alu_carry;
    logic        alu_ovf;
    logic        exec_en;
    logic        reg_wr_en;
    logic        flag_n, flag_z, flag_c, flag_v;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    cx_cond_unit dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .pred_code(pred_code), .set_flags(set_flags), .cmp_op(cmp_op),
        .alu_result(alu_result), .alu_carry(alu_carry), .alu_ovf(alu_ovf),
        .exec_en(exec_en), .reg_wr_en(reg_wr_en),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
    );

    // {pred, nzcv, expected exec}
    typedef struct packed {
        logic [3:0] pred;
        logic [3:0] nzcv;
        logic       exp;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{4'h0, 4'b0100, 1'b1}, '{4'h0, 4'b0000, 1'b0},
        '{4'h1, 4'b0000, 1'b1}, '{4'h2, 4'b0010, 1'b1},
        '{4'h8, 4'b0010, 1'b1}, '{4'h8, 4'b0110, 1'b0},
        '{4'h9, 4'b0110, 1'b1}, '{4'hA, 4'b1000, 1'b0},
        '{4'hA, 4'b1001, 1'b1}, '{4'hC, 4'b1001, 1'b1},
        '{4'hD, 4'b0101, 1'b1}, '{4'hB, 4'b1000, 1'b1},
        '{4'h6, 4'b0001, 1'b1}, '{4'h4, 4'b1000, 1'b1},
        '{4'hE, 4'b0000, 1'b1}, '{4'hF, 4'b0000, 1'b0}
    };

    function automatic logic ref_pass(input logic [3:0] p, input logic [3:0] f);
        logic n, z, c, v;
        {n, z, c, v} = f;
        case (p)
            4'h0: return z;            4'h1: return !z;
            4'h2: return c;            4'h3: return !c;
            4'h4: return n;            4'h5: return !n;
            4'h6: return v;            4'h7: return !v;
            4'h8: return c && !z;      4'h9: return !(c && !z);
            4'hA: return n == v;       4'hB: return n != v;
            4'hC: return !z && n == v; 4'hD: return !(!z && n == v);
            4'hE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] flags();
        return {flag_n, flag_z, flag_c, flag_v};
    endfunction

    // drive one instruction after a falling edge; enables settle 1 ns later
    task automatic issue(input logic [3:0] p, input logic s, input logic cmp,
                         input logic [31:0] res, input logic c, input logic v);
        @(negedge clk);
        issue_valid = 1'b1; pred_code = p; set_flags = s; cmp_op = cmp;
        alu_result = res; alu_carry = c; alu_ovf = v;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        issue_valid = 1'b0; set_flags = 1'b0; cmp_op = 1'b0;
        #1;
    endtask

    // always-executing compare that leaves the flags at f (N and Z not both set)
    task automatic preset(input logic [3:0] f);
        logic [31:0] r;
        r = f[3] ? 32'h8000_0000 : (f[2] ? 32'h0 : 32'h1);
        issue(4'hE, 1'b0, 1'b1, r, f[1], f[0]);
    endtask

    initial begin
        #200000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        issue_valid = 0; pred_code = 0; set_flags = 0; cmp_op = 0;
        alu_result = 0; alu_carry = 0; alu_ovf = 0;
        rst_n = 0;
        #1;
        chk("R1 flags in reset", 32'(flags()), 32'h0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle();
        chk("R1 flags after reset", 32'(flags()), 32'h0);
        chk("R9 idle exec_en", 32'(exec_en), 32'h0);

        // table walk
        foreach (VECS[i]) begin
            preset(VECS[i].nzcv);
            issue(VECS[i].pred, 1'b0, 1'b0, 32'h5, 1'b0, 1'b0);
            chk("R6 preset flags seen next cycle", 32'(flags()), 32'(VECS[i].nzcv));
            chk("R2 table exec_en", 32'(exec_en), 32'(VECS[i].exp));
        end

        // sweep of every reachable flag value and every code
        for (int f = 0; f < 16; f++) begin
            if (f[3] && f[2]) continue;
            for (int p = 0; p < 16; p++) begin
                preset(4'(f));
                issue(4'(p), 1'b0, 1'b0, 32'h5, 1'b0, 1'b0);
                if (p == 14)      chk("R3 always executes", 32'(exec_en), 32'h1);
                else if (p == 15) chk("R4 never executes", 32'(exec_en), 32'h0);
                else              chk("R2 sweep exec_en", 32'(exec_en), 32'(ref_pass(4'(p), 4'(f))));
            end
        end

        // R6: set-flags instruction loads N,C from ALU
        preset(4'b0000);
        issue(4'hE, 1'b1, 1'b0, 32'h8000_0000, 1'b1, 1'b0);
        chk("R7 write enable on S op", 32'(reg_wr_en), 32'h1);
        idle();
        chk("R6 flags after S op", 32'(flags()), 32'hA);
        issue(4'hE, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1);
        idle();
        chk("R6 zero and overflow", 32'(flags()), 32'h5);

        // R7: no S bit leaves flags
        issue(4'hE, 1'b0, 1'b0, 32'h8000_0000, 1'b1, 1'b0);
        chk("R7 reg write", 32'(reg_wr_en), 32'h1);
        idle();
        chk("R7 flags unchanged", 32'(flags()), 32'h5);

        // R5: failed predicate (NE with Z=1) with S and compare
        issue(4'h1, 1'b1, 1'b0, 32'h8000_0000, 1'b1, 1'b0);
        chk("R5 exec_en low", 32'(exec_en), 32'h0);
        chk("R5 reg write low", 32'(reg_wr_en), 32'h0);
        issue(4'h1, 1'b0, 1'b1, 32'h8000_0000, 1'b1, 1'b0);
        idle();
        chk("R5 flags unchanged", 32'(flags()), 32'h5);

        // R8: compare with S low updates flags, no write
        issue(4'hE, 1'b0, 1'b1, 32'h8000_0000, 1'b1, 1'b0);
        chk("R8 no reg write", 32'(reg_wr_en), 32'h0);
        chk("R8 exec_en", 32'(exec_en), 32'h1);
        idle();
        chk("R8 flags loaded", 32'(flags()), 32'hA);

        // R9: not valid, no update
        @(negedge clk);
        issue_valid = 0; pred_code = 4'hE; set_flags = 1; cmp_op = 1;
        alu_result = 0; alu_carry = 0; alu_ovf = 1;
        #1;
        chk("R9 exec_en", 32'(exec_en), 32'h0);
        chk("R9 reg_wr_en", 32'(reg_wr_en), 32'h0);
        idle();
        chk("R9 flags unchanged", 32'(flags()), 32'hA);

        // R6 back to back: compare sets Z, EQ executes next cycle
        issue(4'hE, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0);
        issue(4'h0, 1'b0, 1'b0, 32'h7, 1'b0, 1'b0);
        chk("R6 zero-latency EQ", 32'(exec_en), 32'h1);

        // R1: mid-run reset clears
        preset(4'b1011);
        idle();
        @(negedge clk);
        rst_n = 0;
        #1;
        chk("R1 mid-run reset", 32'(flags()), 32'h0);
        @(negedge clk);
        rst_n = 1;
        idle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule